// File: doc/BRIEF.md
# One-Pulse-Per-Second Divider

This block turns a 10 MHz reference clock into a once-per-second timing mark. A free-running divide counter steps from zero up to one less than the divide ratio and then returns to zero. Each return to zero produces two outputs. The first is a one-cycle second strobe, meant as a clock enable for logic in the same clock domain. The second is a stretched timing pulse whose high time is a parameter. That pulse comes straight from a flip-flop, so it cannot glitch.

An external pin restarts the second count. The pin is active low, because the pad has only a weak pull-up. It is inverted and passed through a short register chain into the clock domain. The synchronised restart then clears the counter through the same path as the terminal-count wrap. The divide ratio, the pulse width and the synchroniser depth are all parameters. The defaults are a 10,000,000 ratio, a 20-cycle pulse and two synchroniser stages.

Top module: `pps_divider`

## Requirements
- R1: While `rst_ni` is low, `pps_o` and `sec_en_o` are low and the count is held at zero.
- R2: With the restart pin idle, `sec_en_o` is high for one cycle after every RATIO-th rising clock edge. The first strobe follows the RATIO-th edge after `rst_ni` is released.
- R3: `sec_en_o` is never high on two consecutive cycles.
- R4: `pps_o` rises on the same edge as `sec_en_o` and stays high for exactly WIDTH cycles. With RATIO=12 and WIDTH=3 it is high after edges 12, 13 and 14, and low after edge 15. With RATIO=100000 and WIDTH=10000 it is high for 10,000 cycles.
- R5: `pps_o` is the output of a flip-flop, with no logic between that flip-flop and the port.
- R6: `cnt_clr_ni` is active low and passes through SYNC_STAGES registers (default 2). If the pin is low at edge a, the counter is cleared and `pps_o` is high after edge a+2.
- R7: While the synchronised restart is active, `pps_o` stays high and `sec_en_o` stays low.
- R8: Take the last edge at which the synchronised restart is still active as edge P. After the pin returns high, `pps_o` stays high through edge P+WIDTH-1 and falls after edge P+WIDTH. The next `sec_en_o` follows edge P+RATIO.
- R9: If the synchronised restart and the terminal count fall on the same edge, the restart wins. No strobe is issued, `pps_o` goes high, and the next strobe follows RATIO edges later.
- R10: The design requires 1 <= WIDTH < RATIO and RATIO >= 2. The counter width is ceil(log2(RATIO)), and the count never reaches RATIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (10 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| cnt_clr_ni | input | 1 | Active-low counter restart pin, asynchronous to the clock |
| pps_o | output | 1 | Registered stretched timing pulse, WIDTH cycles high |
| sec_en_o | output | 1 | One-cycle second strobe for same-domain logic |

## Verification
The terminal-count wrap and the synchronised restart can reach the divide counter on the same edge, and both want to clear it. The bench provokes this by pulsing the restart pin low for exactly one cycle, timed so that after the two synchroniser stages the restart lands on the edge where the count sits at RATIO-1. It then judges that no second strobe appears on that edge, that the pulse output is raised, and that the next strobe comes a full RATIO cycles later. Separately, a second instance sized for a 1 ms pulse width is run through one full period to confirm the strobe spacing and the pulse length at a realistic scale.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int unsigned DEF_RATIO       = 10_000_000;
  localparam int unsigned DEF_WIDTH       = 20;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned cnt_bits(input int unsigned ratio);
    return (ratio < 2) ? 1 : $clog2(ratio);
  endfunction
endpackage

// File: rtl/pps_restart_sync.sv
module pps_restart_sync #(
  parameter int unsigned STAGES = pps_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic restart_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= ~pin_ni;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], ~pin_ni};
      end
    end
  endgenerate

  assign restart_o = sync_q[STAGES-1];

  initial assert_stages_R6: assert (STAGES >= 1) else $error("STAGES must be at least 1");
endmodule

// File: rtl/pps_div_counter.sv
module pps_div_counter #(
  parameter int unsigned RATIO = pps_pkg::DEF_RATIO,
  localparam int unsigned CNT_W = pps_pkg::cnt_bits(RATIO)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             sec_en_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  assign wrap_o = (cnt_q == LAST);

  // restart and terminal count share the clear path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || wrap_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // restart suppresses the strobe when both coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= wrap_o && !restart_i;
  end

  assign cnt_o    = cnt_q;
  assign sec_en_o = en_q;

  assert_cnt_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_restart_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
  assert_single_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> !en_q);
  assert_strobe_at_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> (cnt_q == '0));
  assert_restart_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !en_q);

  initial assert_ratio_R10: assert (RATIO >= 2) else $error("RATIO must be at least 2");
endmodule

// File: rtl/pps_stretch.sv
module pps_stretch #(
  parameter int unsigned RATIO = pps_pkg::DEF_RATIO,
  parameter int unsigned WIDTH = pps_pkg::DEF_WIDTH,
  localparam int unsigned CNT_W = pps_pkg::cnt_bits(RATIO)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pps_o
);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(WIDTH - 1);

  logic pps_q;

  // set dominates clear: a held restart keeps the pulse high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pps_q <= 1'b0;
    else if (restart_i || wrap_i)  pps_q <= 1'b1;
    else if (cnt_i == END_CNT)     pps_q <= 1'b0;
  end

  assign pps_o = pps_q;

  assert_hold_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> pps_q);
  assert_rise_on_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !pps_q) |=> pps_q);

  initial assert_width_R10: assert (WIDTH >= 1 && WIDTH < RATIO)
    else $error("WIDTH must satisfy 1 <= WIDTH < RATIO");
endmodule

// File: rtl/pps_divider.sv
module pps_divider #(
  parameter int unsigned RATIO       = pps_pkg::DEF_RATIO,
  parameter int unsigned WIDTH       = pps_pkg::DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = pps_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_clr_ni,
  output logic pps_o,
  output logic sec_en_o
);
  localparam int unsigned CNT_W = pps_pkg::cnt_bits(RATIO);

  logic             restart;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  pps_restart_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_ni    (cnt_clr_ni),
    .restart_o (restart)
  );

  pps_div_counter #(.RATIO(RATIO)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .cnt_o     (cnt),
    .wrap_o    (wrap),
    .sec_en_o  (sec_en_o)
  );

  pps_stretch #(.RATIO(RATIO), .WIDTH(WIDTH)) u_str (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .wrap_i    (wrap),
    .cnt_i     (cnt),
    .pps_o     (pps_o)
  );

  assert_pps_with_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_en_o |-> pps_o);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!pps_o && !sec_en_o));
endmodule

// File: tb/pps_divider_tb.sv
module pps_divider_tb;
  localparam int R_S = 12;
  localparam int W_S = 3;
  localparam int R_L = 100_000;
  localparam int W_L = 10_000;
  localparam int NV  = 11;
  // {edge index, expected pps, expected strobe}
  localparam logic [9:0] TAB [NV] = '{
    {8'd1, 1'b0, 1'b0}, {8'd11, 1'b0, 1'b0}, {8'd12, 1'b1, 1'b1},
    {8'd13, 1'b1, 1'b0}, {8'd14, 1'b1, 1'b0}, {8'd15, 1'b0, 1'b0},
    {8'd23, 1'b0, 1'b0}, {8'd24, 1'b1, 1'b1}, {8'd26, 1'b1, 1'b0},
    {8'd27, 1'b0, 1'b0}, {8'd36, 1'b1, 1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1;
  logic clr_l_n = 1'b1;
  logic pps_s, en_s, pps_l, en_l;
  int n_chk = 0;
  int n_fail = 0;
  int cur = 0;

  always #2 clk = ~clk;

  pps_divider #(.RATIO(R_S), .WIDTH(W_S)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clr_ni(clr_n), .pps_o(pps_s), .sec_en_o(en_s));

  pps_divider #(.RATIO(R_L), .WIDTH(W_L)) u_dut_l (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clr_ni(clr_l_n), .pps_o(pps_l), .sec_en_o(en_l));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s edge %0d: actual %b expected %b", req, cur, act, exp);
    end
  endtask

  // advance to edge k after reset release, sample 1 ns after it
  task automatic go(input int k);
    while (cur < k) begin
      @(posedge clk);
      cur++;
    end
    #1;
  endtask

  initial begin
    #(190_000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired at edge %0d", cur);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 pps in reset", pps_s, 1'b0);
    check("R1 strobe in reset", en_s, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R4: vector table for the small instance
    for (int i = 0; i < NV; i++) begin
      go(int'(TAB[i][9:2]));
      check("R4 pps vector", pps_s, TAB[i][1]);
      check("R2 strobe vector", en_s, TAB[i][0]);
    end
    go(37);
    check("R3 strobe single cycle", en_s, 1'b0);

    // R6 R7: restart pin low before edge 41
    go(40);
    @(negedge clk);
    clr_n = 1'b0;
    go(42);
    check("R6 not yet cleared", pps_s, 1'b0);
    go(43);
    check("R6 cleared after two stages", pps_s, 1'b1);
    for (int k = 44; k <= 48; k++) begin
      go(k);
      check("R7 pps held", pps_s, 1'b1);
      check("R7 strobe held off", en_s, 1'b0);
    end
    @(negedge clk);
    clr_n = 1'b1;
    // R8: last active restart edge P = 50
    go(52);
    check("R8 pps high at P+W-1", pps_s, 1'b1);
    go(53);
    check("R8 pps low at P+W", pps_s, 1'b0);
    go(61);
    check("R8 no early strobe", en_s, 1'b0);
    go(62);
    check("R8 strobe at P+RATIO", en_s, 1'b1);
    check("R8 pps at P+RATIO", pps_s, 1'b1);

    // R9: restart lands on the terminal edge 74
    go(71);
    @(negedge clk);
    clr_n = 1'b0;
    go(72);
    @(negedge clk);
    clr_n = 1'b1;
    go(73);
    check("R9 pps low before coincide", pps_s, 1'b0);
    go(74);
    check("R9 strobe suppressed", en_s, 1'b0);
    check("R9 pps raised", pps_s, 1'b1);
    go(77);
    check("R9 pps width after coincide", pps_s, 1'b0);
    go(85);
    check("R9 no early strobe", en_s, 1'b0);
    go(86);
    check("R9 strobe RATIO later", en_s, 1'b1);

    // R2 R4: large instance, one full period
    go(R_L - 1);
    check("R2 large no early strobe", en_l, 1'b0);
    check("R4 large pps low", pps_l, 1'b0);
    go(R_L);
    check("R2 large strobe", en_l, 1'b1);
    check("R5 large pps rises", pps_l, 1'b1);
    go(R_L + 1);
    check("R3 large strobe single", en_l, 1'b0);
    go(R_L + W_L - 1);
    check("R4 large pps last high", pps_l, 1'b1);
    go(R_L + W_L);
    check("R4 large pps falls", pps_l, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule